// File: doc/BRIEF.md
# Display Controller Command Decoder

This block sits behind the shared command/parameter FIFO of a raster display controller. Each byte that leaves the FIFO carries a tag that marks it as either a command byte or a parameter byte. A command byte selects an operation. The parameter bytes that follow it are unpacked into configuration registers. The decoder handles several cases:

- Timing fields that straddle byte boundaries are reassembled from the bytes that carry them.
- A new command byte ends any parameter sequence that is still in progress.
- Surplus parameters are dropped.
- Unknown commands are dropped together with their parameters.

The outputs are steady configuration levels for the video timing generator, the memory access unit and the cursor logic. Those consumers are not part of this block.

Top module: `disp_cmd_decoder`

## Requirements
- R1: While rst_n is low, and after it is released, every configuration output is zero except blank_en, which is 1. This means display_en=0, master=0 and disp_kind=0.
- R2: Command 0x00 (timing setup) takes 8 parameters, numbered P0 to P7. They are unpacked as follows:
  - P0 is the mode byte.
  - P1 gives h_words_m2.
  - P2[4:0] gives hsync_m1, and P2[7:5] gives vsync_w[2:0].
  - P3[1:0] gives vsync_w[4:3], and P3[7:2] gives hfp_m1.
  - P4[5:0] gives hbp_m1.
  - P5[5:0] gives vfp.
  - P6 gives active_lines[7:0].
  - P7[1:0] gives active_lines[9:8], and P7[7:2] gives vbp.
- R3: The mode byte is decoded as follows:
  - disp_kind = {bit5, bit1}: 00 is mixed, 01 is graphics only, 10 is character only.
  - interlace = bit3.
  - dram_refresh = bit2.
  - draw_blank_only = bit4.
- R4: The command byte 0x00 on its own sets blank_en and clears display_en and master. Commands 0x6F, 0x6B and 0x0D take no parameters:
  - 0x6F sets master.
  - 0x6B sets display_en.
  - 0x0D clears blank_en.
- R5: Command 0x47 loads its single parameter into pitch. Command 0x46 loads its single parameter into zoom.
- R6: Command 0x70 writes parameter-RAM bytes B0 to B3 in order:
  - part_start = {B2[1:0], B1, B0}.
  - part_len = {B3[5:0], B2[7:4]}.
  - part_graphics = B3[6].
  - part_wide = B3[7].
- R7: Command 0x4B takes two bytes, C0 and C1:
  - C0[7] gives cur_en, and C0[4:0] gives row_lines_m1.
  - C1[4:0] gives cur_top, C1[5] gives cur_steady, and C1[7:6] gives blink_lo.
- R8: Command 0x4C takes three bytes, F0, F1 and F2. fig_ctrl = F0 and fig_len = {F2, F1}.
- R9: Parameters beyond a command's expected count change no output.
- R10: Any command byte restarts the parameter index at zero. A sequence that is cut short keeps the fields it had already loaded, and the following parameters belong to the new command.
- R11: An unknown command byte changes no output, and its parameters are discarded until the next command.
- R12: A byte is accepted only when in_valid is high. Its effect appears on the outputs one clock edge after it is accepted. When in_valid is low, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte from the FIFO is present this cycle |
| in_is_cmd | input | 1 | 1: command byte, 0: parameter byte |
| in_byte | input | 8 | FIFO byte |
| disp_kind | output | 2 | 00 mixed, 01 graphics, 10 character |
| interlace | output | 1 | Interlace enabled |
| dram_refresh | output | 1 | DRAM refresh cycles enabled |
| draw_blank_only | output | 1 | Drawing restricted to blanking time |
| h_words_m2 | output | 8 | Active words per line minus 2 |
| hsync_m1 | output | 5 | Horizontal sync width minus 1 |
| vsync_w | output | 5 | Vertical sync width |
| hfp_m1 | output | 6 | Horizontal front porch minus 1 |
| hbp_m1 | output | 6 | Horizontal back porch minus 1 |
| vfp | output | 6 | Vertical front porch |
| active_lines | output | 10 | Active lines per frame |
| vbp | output | 6 | Vertical back porch |
| master | output | 1 | Master sync mode |
| pitch | output | 8 | Memory words per line |
| part_start | output | 18 | Partition start address |
| part_len | output | 10 | Partition length in lines |
| part_graphics | output | 1 | Partition is a graphics area |
| part_wide | output | 1 | Wide memory access |
| cur_en | output | 1 | Cursor enable |
| row_lines_m1 | output | 5 | Lines per character row minus 1 |
| cur_top | output | 5 | Cursor top line |
| cur_steady | output | 1 | Steady (1) or blinking (0) cursor |
| blink_lo | output | 2 | Blink rate low bits |
| zoom | output | 8 | Zoom factor byte |
| fig_ctrl | output | 8 | Figure control byte |
| fig_len | output | 16 | Figure length field |
| display_en | output | 1 | Display running |
| blank_en | output | 1 | Display blanked |

## Verification
Every output is a register that a single accepted byte writes. The result of a byte is therefore due on the first rising edge after that byte is presented.

The bench drives each byte at a falling edge and drops in_valid at the next falling edge. It samples outputs only at that falling edge or later, which is half a cycle after the capturing edge. A check never looks at a value before its edge or on the edge itself.

The checks that test for no change (surplus, unknown, idle) sample after the stray stimulus and before the next command, so any corruption is still visible.

// File: rtl/disp_cmd_decoder.sv
module disp_cmd_decoder #(
  parameter int IDX_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_is_cmd,
  input  logic [7:0]  in_byte,
  output logic [1:0]  disp_kind,
  output logic        interlace,
  output logic        dram_refresh,
  output logic        draw_blank_only,
  output logic [7:0]  h_words_m2,
  output logic [4:0]  hsync_m1,
  output logic [4:0]  vsync_w,
  output logic [5:0]  hfp_m1,
  output logic [5:0]  hbp_m1,
  output logic [5:0]  vfp,
  output logic [9:0]  active_lines,
  output logic [5:0]  vbp,
  output logic        master,
  output logic [7:0]  pitch,
  output logic [17:0] part_start,
  output logic [9:0]  part_len,
  output logic        part_graphics,
  output logic        part_wide,
  output logic        cur_en,
  output logic [4:0]  row_lines_m1,
  output logic [4:0]  cur_top,
  output logic        cur_steady,
  output logic [1:0]  blink_lo,
  output logic [7:0]  zoom,
  output logic [7:0]  fig_ctrl,
  output logic [15:0] fig_len,
  output logic        display_en,
  output logic        blank_en
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  typedef enum logic [2:0] {
    K_NONE, K_TIMING, K_PITCH, K_PRAM, K_CURSOR, K_ZOOM, K_FIG
  } kind_t;

  kind_t            cur;
  logic [IDX_W-1:0] idx;
  logic [7:0]       mode;

  assign disp_kind       = {mode[5], mode[1]};
  assign interlace       = mode[3];
  assign dram_refresh    = mode[2];
  assign draw_blank_only = mode[4];

  wire take_cmd = in_valid && in_is_cmd;
  wire take_par = in_valid && !in_is_cmd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= K_NONE;
      idx <= '0;
      mode <= '0;
      h_words_m2 <= '0;
      hsync_m1 <= '0;
      vsync_w <= '0;
      hfp_m1 <= '0;
      hbp_m1 <= '0;
      vfp <= '0;
      active_lines <= '0;
      vbp <= '0;
      master <= 1'b0;
      pitch <= '0;
      part_start <= '0;
      part_len <= '0;
      part_graphics <= 1'b0;
      part_wide <= 1'b0;
      cur_en <= 1'b0;
      row_lines_m1 <= '0;
      cur_top <= '0;
      cur_steady <= 1'b0;
      blink_lo <= '0;
      zoom <= '0;
      fig_ctrl <= '0;
      fig_len <= '0;
      display_en <= 1'b0;
      blank_en <= 1'b1;
    end else if (take_cmd) begin
      idx <= '0;
      cur <= K_NONE;
      case (in_byte)
        8'h00: begin
          cur <= K_TIMING;
          master <= 1'b0;
          display_en <= 1'b0;
          blank_en <= 1'b1;
        end
        8'h6F: master <= 1'b1;
        8'h6B: display_en <= 1'b1;
        8'h0D: blank_en <= 1'b0;
        8'h47: cur <= K_PITCH;
        8'h46: cur <= K_ZOOM;
        8'h70: cur <= K_PRAM;
        8'h4B: cur <= K_CURSOR;
        8'h4C: cur <= K_FIG;
        default: cur <= K_NONE;
      endcase
    end else if (take_par) begin
      if (idx != IDX_MAX) idx <= idx + 1'b1;
      case (cur)
        K_TIMING:
          case (idx)
            0: mode <= in_byte;
            1: h_words_m2 <= in_byte;
            2: begin
              hsync_m1 <= in_byte[4:0];
              vsync_w[2:0] <= in_byte[7:5];
            end
            3: begin
              vsync_w[4:3] <= in_byte[1:0];
              hfp_m1 <= in_byte[7:2];
            end
            4: hbp_m1 <= in_byte[5:0];
            5: vfp <= in_byte[5:0];
            6: active_lines[7:0] <= in_byte;
            7: begin
              active_lines[9:8] <= in_byte[1:0];
              vbp <= in_byte[7:2];
            end
            default: ;
          endcase
        K_PITCH: if (idx == 0) pitch <= in_byte;
        K_ZOOM:  if (idx == 0) zoom <= in_byte;
        K_PRAM:
          case (idx)
            0: part_start[7:0] <= in_byte;
            1: part_start[15:8] <= in_byte;
            2: begin
              part_start[17:16] <= in_byte[1:0];
              part_len[3:0] <= in_byte[7:4];
            end
            3: begin
              part_len[9:4] <= in_byte[5:0];
              part_graphics <= in_byte[6];
              part_wide <= in_byte[7];
            end
            default: ;
          endcase
        K_CURSOR:
          case (idx)
            0: begin
              cur_en <= in_byte[7];
              row_lines_m1 <= in_byte[4:0];
            end
            1: begin
              cur_top <= in_byte[4:0];
              cur_steady <= in_byte[5];
              blink_lo <= in_byte[7:6];
            end
            default: ;
          endcase
        K_FIG:
          case (idx)
            0: fig_ctrl <= in_byte;
            1: fig_len[7:0] <= in_byte;
            2: fig_len[15:8] <= in_byte;
            default: ;
          endcase
        default: ;
      endcase
    end
  end

  wire [159:0] cfg_all = {mode, h_words_m2, hsync_m1, vsync_w, hfp_m1, hbp_m1, vfp,
                          active_lines, vbp, master, pitch, part_start, part_len,
                          part_graphics, part_wide, cur_en, row_lines_m1, cur_top,
                          cur_steady, blink_lo, zoom, fig_ctrl, fig_len, display_en,
                          blank_en, 6'd0};

  a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cfg_all));

  a_r11_unknown_params_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (take_par && cur == K_NONE) |=> $stable(cfg_all));

  a_r9_surplus_pitch: assert property (@(posedge clk) disable iff (!rst_n)
    (take_par && cur == K_PITCH && idx != 0) |=> $stable(cfg_all));

  a_r5_pitch_load: assert property (@(posedge clk) disable iff (!rst_n)
    (take_par && cur == K_PITCH && idx == 0) |=> pitch == $past(in_byte));

  a_r4_unblank: assert property (@(posedge clk) disable iff (!rst_n)
    (take_cmd && in_byte == 8'h0D) |=> !blank_en);

  a_r4_display_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !take_cmd |=> $stable(display_en) && $stable(blank_en) && $stable(master));

  a_r10_cmd_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    take_cmd |=> idx == 0);
endmodule

// File: tb/tb_disp_cmd_decoder.sv
module tb_disp_cmd_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_is_cmd = 1'b0;
  logic [7:0] in_byte = 8'h00;

  logic [1:0] disp_kind;
  logic interlace, dram_refresh, draw_blank_only;
  logic [7:0] h_words_m2;
  logic [4:0] hsync_m1, vsync_w;
  logic [5:0] hfp_m1, hbp_m1, vfp, vbp;
  logic [9:0] active_lines;
  logic master;
  logic [7:0] pitch;
  logic [17:0] part_start;
  logic [9:0] part_len;
  logic part_graphics, part_wide, cur_en;
  logic [4:0] row_lines_m1, cur_top;
  logic cur_steady;
  logic [1:0] blink_lo;
  logic [7:0] zoom, fig_ctrl;
  logic [15:0] fig_len;
  logic display_en, blank_en;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  disp_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_cmd(in_is_cmd), .in_byte(in_byte),
    .disp_kind(disp_kind), .interlace(interlace), .dram_refresh(dram_refresh),
    .draw_blank_only(draw_blank_only), .h_words_m2(h_words_m2), .hsync_m1(hsync_m1),
    .vsync_w(vsync_w), .hfp_m1(hfp_m1), .hbp_m1(hbp_m1), .vfp(vfp),
    .active_lines(active_lines), .vbp(vbp), .master(master), .pitch(pitch),
    .part_start(part_start), .part_len(part_len), .part_graphics(part_graphics),
    .part_wide(part_wide), .cur_en(cur_en), .row_lines_m1(row_lines_m1),
    .cur_top(cur_top), .cur_steady(cur_steady), .blink_lo(blink_lo), .zoom(zoom),
    .fig_ctrl(fig_ctrl), .fig_len(fig_len), .display_en(display_en), .blank_en(blank_en)
  );

  localparam int NSEQ = 29;
  localparam logic [8:0] SEQ [NSEQ] = '{
    9'h100, 9'h012, 9'h04E, 9'h069, 9'h015, 9'h0C7, 9'h00A, 9'h0E0, 9'h085,
    9'h16F,
    9'h147, 9'h050, 9'h0AA,
    9'h170, 9'h034, 9'h012, 9'h0E2, 9'h0C1,
    9'h14B, 9'h087, 9'h0E5,
    9'h146, 9'h003,
    9'h16B, 9'h10D,
    9'h14C, 9'h002, 9'h010, 9'h020
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic is_cmd, input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_is_cmd = is_cmd;
    in_byte = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 blank_en", 32'(blank_en), 1);
    chk("R1 display_en", 32'(display_en), 0);
    chk("R1 master", 32'(master), 0);
    chk("R1 timing", {h_words_m2, pitch, zoom, 6'(vfp), 2'(disp_kind)}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NSEQ; i++) put(SEQ[i][8], SEQ[i][7:0]);

    chk("R2 h_words_m2", 32'(h_words_m2), 32'h4E);
    chk("R2 hsync_m1", 32'(hsync_m1), 9);
    chk("R2 vsync_w", 32'(vsync_w), 11);
    chk("R2 hfp_m1", 32'(hfp_m1), 5);
    chk("R2 hbp_m1", 32'(hbp_m1), 7);
    chk("R2 vfp", 32'(vfp), 10);
    chk("R2 active_lines", 32'(active_lines), 480);
    chk("R2 vbp", 32'(vbp), 32'h21);
    chk("R3 disp_kind graphics", 32'(disp_kind), 1);
    chk("R3 draw_blank_only", 32'(draw_blank_only), 1);
    chk("R3 interlace", 32'(interlace), 0);
    chk("R4 master", 32'(master), 1);
    chk("R4 display_en", 32'(display_en), 1);
    chk("R4 blank_en", 32'(blank_en), 0);
    chk("R5 R9 pitch", 32'(pitch), 32'h50);
    chk("R5 zoom", 32'(zoom), 3);
    chk("R6 part_start", 32'(part_start), 32'h21234);
    chk("R6 part_len", 32'(part_len), 32'h1E);
    chk("R6 part flags", {part_wide, part_graphics}, 3);
    chk("R7 cursor0", {cur_en, row_lines_m1}, {1'b1, 5'd7});
    chk("R7 cursor1", {blink_lo, cur_steady, cur_top}, {2'd3, 1'b1, 5'd5});
    chk("R8 fig_ctrl", 32'(fig_ctrl), 2);
    chk("R8 fig_len", 32'(fig_len), 32'h2010);

    // R9 surplus parameters on a multi-byte command
    put(1'b1, 8'h4C); put(1'b0, 8'h07); put(1'b0, 8'h11); put(1'b0, 8'h22); put(1'b0, 8'h99);
    chk("R9 fig_ctrl after surplus", 32'(fig_ctrl), 7);
    chk("R9 fig_len after surplus", 32'(fig_len), 32'h2211);

    // R11 unknown command and its parameters
    put(1'b1, 8'h99); put(1'b0, 8'h77); put(1'b0, 8'h66);
    chk("R11 pitch", 32'(pitch), 32'h50);
    chk("R11 zoom", 32'(zoom), 3);
    chk("R11 fig_ctrl", 32'(fig_ctrl), 7);
    chk("R11 display", {display_en, blank_en, master}, 3'b101);

    // R12 idle cycles with a byte on the bus but no valid
    @(negedge clk);
    in_is_cmd = 1'b1; in_byte = 8'h00;
    repeat (3) @(negedge clk);
    chk("R12 idle display_en", 32'(display_en), 1);
    chk("R12 idle master", 32'(master), 1);

    // R10 command cuts a sequence short
    put(1'b1, 8'h47);
    put(1'b1, 8'h46); put(1'b0, 8'h09);
    chk("R10 zoom after cut", 32'(zoom), 9);
    chk("R10 pitch kept", 32'(pitch), 32'h50);

    // R4 timing command byte alone, then R10 interrupted timing sequence
    put(1'b1, 8'h00);
    chk("R4 cmd00 display_en", 32'(display_en), 0);
    chk("R4 cmd00 blank_en", 32'(blank_en), 1);
    chk("R4 cmd00 master", 32'(master), 0);
    put(1'b0, 8'h2C);
    put(1'b1, 8'h47); put(1'b0, 8'h20);
    chk("R10 h_words kept", 32'(h_words_m2), 32'h4E);
    chk("R10 pitch new", 32'(pitch), 32'h20);
    chk("R3 disp_kind char", 32'(disp_kind), 2);
    chk("R3 interlace", 32'(interlace), 1);
    chk("R3 dram_refresh", 32'(dram_refresh), 1);
    chk("R3 draw_blank_only clear", 32'(draw_blank_only), 0);

    // R3 mixed mode
    put(1'b1, 8'h00); put(1'b0, 8'h00);
    chk("R3 disp_kind mixed", 32'(disp_kind), 0);

    // R1 reset mid-run
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset pitch", 32'(pitch), 0);
    chk("R1 reset blank_en", 32'(blank_en), 1);
    rst_n = 1'b1;

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1ms;
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule